// File: doc/BRIEF.md
# Memory-Reference Address Sequencer

This block works out where a memory-reference instruction's operand lives in a 15-bit address space split into eight fields of 4096 words each. On a start pulse it latches the 12-bit instruction word, the 15-bit program counter, the 3-bit data field and the 3-bit instruction field. It then forms the operand address from a 7-bit offset, which lands either in page zero or in the program counter's current page. When the reference is indirect, it reads a pointer through a single-port memory port. For certain pointer locations it writes the pointer back incremented. The block reports the final operand address, the following program counter and the return value that a subroutine call would store.

The sequencer does no arithmetic on operands. The execute stage takes the final address and the program-counter values when the block pulses `done`. An interrupt request that arrives with start replaces the instruction with a call to location 0 of field 0.

Top module: `mref_addr_seq`

## Requirements
- R1: While reset is held and right after it, `done`, `busy`, `mem_rd` and `mem_wr` are all low.
- R2: Opcode is instruction bits 11:9, with memory-reference opcodes 0 to 5. When bit 8 is 0 (direct) and bit 7 is 0 (page zero), the low 12 address bits are five zeros followed by instruction bits 6:0. `done` pulses exactly one cycle after start, with no memory access.
- R3: When bit 7 is 1 (current page), address bits 11:7 come from program counter bits 11:7, and bits 6:0 still come from the instruction.
- R4: When bit 8 is 1 (indirect), the pointer is read at {data field, low 12 bits from R2/R3}. The pointer becomes the low 12 bits of the final address. Read data arrives one cycle after `mem_rd`, and `done` pulses three cycles after start.
- R5: For opcodes 0, 1 and 3, an indirect reference whose pointer location has low 12 bits in octal 0010 to 0017 writes the pointer plus one (modulo 4096) back to that location. The write happens in the cycle after the read data arrives, the incremented value is used as the final address, and `done` pulses four cycles after start. Opcodes 2, 4 and 5 never write.
- R6: Address bits 14:12 of the final address come from the data field for opcodes 0 to 3 and from the instruction field for opcodes 4 and 5.
- R7: For opcodes other than 4 and 5, `next_pc` is the program counter with its low 12 bits incremented modulo 4096 and bits 14:12 kept.
- R8: Opcode 5 (jump) gives `next_pc` = {instruction field, final low 12 bits}.
- R9: Opcode 4 (call) gives `next_pc` = {instruction field, final low 12 bits + 1 modulo 4096}. `ret_pc` is the sequential value from R7.
- R10: An interrupt at start acts as a direct page-zero call to offset 0 (instruction octal 4000). It gives `op_addr` = 0, `next_pc` = 1 and `ret_pc` = the unchanged program counter, and both field inputs must be zero.
- R11: Opcodes 6 and 7 access no memory, give `op_addr` = 0 and the R7 `next_pc`, and pulse `done` one cycle after start.
- R12: `done` is a one-cycle pulse. `busy` is high from the cycle after start until `done`, and a start while busy is ignored.
- R13: `mem_rd` and `mem_wr` are never high together, and each is high for at most one cycle per reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin address formation (accepted when idle) |
| instr | input | 12 | Instruction word |
| pc | input | 15 | Current program counter |
| dfld | input | 3 | Data field register |
| ifld | input | 3 | Instruction field register |
| irq | input | 1 | Interrupt taken: force call to location 0 |
| busy | output | 1 | Sequence in progress |
| mem_addr | output | 15 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Memory read data, valid one cycle after mem_rd |
| done | output | 1 | One-cycle completion pulse |
| op_addr | output | 15 | Final operand address |
| next_pc | output | 15 | Following program counter |
| ret_pc | output | 15 | Return value for a call |

## Verification
On every cycle the checker enforces the following:
- the strobe ordering: a write only ever follows a read by two cycles, and the two strobes are never high together;
- that a write-back carries the previous cycle's read data plus one, to an autoincrement location;
- that `done` is a single pulse;
- the one-cycle completion of direct references;
- the zero-field precondition for interrupts.

Only the bench scenarios can show that the final address, the next and return program counters, and the field and page selection come out right. These scenarios also cover the wrap cases, pointer octal 7777 and program counter low bits octal 7777, and the rule that a start during a running sequence changes nothing.

// File: rtl/mref_pkg.sv
package mref_pkg;
    localparam int WORD_W  = 12;
    localparam int FLD_W   = 3;
    localparam int OFS_W   = 7;
    localparam int ADDR_W  = WORD_W + FLD_W;
    localparam int OP_W    = 3;
    localparam int AUTO_LO = 8;
    localparam int AUTO_HI = 15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WAIT,
        ST_WB,
        ST_FIN
    } seq_st_e;

    typedef struct packed {
        seq_st_e             st;
        logic [ADDR_W-1:0]   ptr;
        logic [ADDR_W-1:0]   addr;
        logic [WORD_W-1:0]   wdata;
        logic [ADDR_W-1:0]   npc;
        logic [ADDR_W-1:0]   ret;
        logic [ADDR_W-1:0]   pc;
        logic [FLD_W-1:0]    ifld;
        logic [FLD_W-1:0]    dfld;
        logic                irq;
        logic                jump;
        logic                call;
        logic                inc;
    } seq_regs_t;
endpackage

// File: rtl/mref_ea_form.sv
module mref_ea_form
    import mref_pkg::*;
(
    input  logic [WORD_W-1:0]     instr,
    input  logic [WORD_W-OFS_W-1:0] pc_page,
    input  logic                  irq,
    output logic                  is_mem,
    output logic                  is_ind,
    output logic                  is_jump,
    output logic                  is_call,
    output logic                  auto_inc,
    output logic [WORD_W-1:0]     lo
);
    localparam logic [WORD_W-1:0] IRQ_WORD = WORD_W'(12'o4000);

    logic [WORD_W-1:0] eff;
    logic [OP_W-1:0]   op;
    logic              non_redir;
    logic              in_auto;

    always_comb begin
        eff       = irq ? IRQ_WORD : instr;
        op        = eff[WORD_W-1 -: OP_W];
        is_mem    = (op <= OP_W'(5));
        is_ind    = is_mem && eff[OFS_W+1];
        is_jump   = (op == OP_W'(5));
        is_call   = (op == OP_W'(4));
        lo        = {(eff[OFS_W] ? pc_page : '0), eff[OFS_W-1:0]};
        non_redir = (op == OP_W'(0)) || (op == OP_W'(1)) || (op == OP_W'(3));
        in_auto   = (lo >= WORD_W'(AUTO_LO)) && (lo <= WORD_W'(AUTO_HI));
        auto_inc  = is_ind && non_redir && in_auto;
    end
endmodule

// File: rtl/mref_pc_next.sv
module mref_pc_next
    import mref_pkg::*;
(
    input  logic [ADDR_W-1:0] pc,
    input  logic              irq,
    input  logic [FLD_W-1:0]  ifld,
    input  logic [WORD_W-1:0] tgt,
    input  logic              jump,
    input  logic              call,
    output logic [ADDR_W-1:0] npc,
    output logic [ADDR_W-1:0] ret
);
    logic [ADDR_W-1:0] seq;

    always_comb begin
        seq = {pc[ADDR_W-1:WORD_W], pc[WORD_W-1:0] + WORD_W'(1)};
        ret = irq ? pc : seq;
        if (call)
            npc = {ifld, tgt + WORD_W'(1)};
        else if (jump)
            npc = {ifld, tgt};
        else
            npc = seq;
    end
endmodule

// File: rtl/mref_addr_seq.sv
module mref_addr_seq
    import mref_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [11:0]       instr,
    input  logic [14:0]       pc,
    input  logic [2:0]        dfld,
    input  logic [2:0]        ifld,
    input  logic              irq,
    output logic              busy,
    output logic [14:0]       mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [11:0]       mem_wdata,
    input  logic [11:0]       mem_rdata,
    output logic              done,
    output logic [14:0]       op_addr,
    output logic [14:0]       next_pc,
    output logic [14:0]       ret_pc
);
    seq_regs_t q, d;

    logic              ea_mem, ea_ind, ea_jump, ea_call, ea_inc;
    logic [WORD_W-1:0] ea_lo;

    mref_ea_form u_ea (
        .instr    (instr),
        .pc_page  (pc[WORD_W-1:OFS_W]),
        .irq      (irq),
        .is_mem   (ea_mem),
        .is_ind   (ea_ind),
        .is_jump  (ea_jump),
        .is_call  (ea_call),
        .auto_inc (ea_inc),
        .lo       (ea_lo)
    );

    logic              idle;
    logic [ADDR_W-1:0] pn_pc;
    logic              pn_irq, pn_jump, pn_call;
    logic [FLD_W-1:0]  pn_ifld;
    logic [WORD_W-1:0] pn_tgt, fin;
    logic [ADDR_W-1:0] pn_npc, pn_ret;

    always_comb begin
        idle    = (q.st == ST_IDLE);
        fin     = q.inc ? mem_rdata + WORD_W'(1) : mem_rdata;
        pn_pc   = idle ? pc      : q.pc;
        pn_irq  = idle ? irq     : q.irq;
        pn_ifld = idle ? ifld    : q.ifld;
        pn_jump = idle ? ea_jump : q.jump;
        pn_call = idle ? ea_call : q.call;
        pn_tgt  = idle ? ea_lo   : fin;
    end

    mref_pc_next u_pn (
        .pc   (pn_pc),
        .irq  (pn_irq),
        .ifld (pn_ifld),
        .tgt  (pn_tgt),
        .jump (pn_jump),
        .call (pn_call),
        .npc  (pn_npc),
        .ret  (pn_ret)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.pc   = pc;
                    d.irq  = irq;
                    d.ifld = ifld;
                    d.dfld = dfld;
                    d.jump = ea_jump;
                    d.call = ea_call;
                    d.inc  = ea_inc;
                    d.ret  = pn_ret;
                    d.ptr  = {dfld, ea_lo};
                    d.npc  = pn_npc;
                    if (!ea_mem) begin
                        d.addr = '0;
                        d.st   = ST_FIN;
                    end else if (!ea_ind) begin
                        d.addr = {(ea_jump || ea_call) ? ifld : dfld, ea_lo};
                        d.st   = ST_FIN;
                    end else begin
                        d.st   = ST_RD;
                    end
                end
            end
            ST_RD:   d.st = ST_WAIT;
            ST_WAIT: begin
                d.addr  = {(q.jump || q.call) ? q.ifld : q.dfld, fin};
                d.npc   = pn_npc;
                d.wdata = fin;
                d.st    = q.inc ? ST_WB : ST_FIN;
            end
            ST_WB:   d.st = ST_FIN;
            ST_FIN:  d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != ST_IDLE);
    assign mem_rd    = (q.st == ST_RD);
    assign mem_wr    = (q.st == ST_WB);
    assign mem_addr  = q.ptr;
    assign mem_wdata = q.wdata;
    assign done      = (q.st == ST_FIN);
    assign op_addr   = q.addr;
    assign next_pc   = q.npc;
    assign ret_pc    = q.ret;
endmodule

// File: rtl/mref_addr_seq_chk.sv
module mref_addr_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [11:0] instr,
    input logic [2:0]  dfld,
    input logic [2:0]  ifld,
    input logic        irq,
    input logic        busy,
    input logic [14:0] mem_addr,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic [11:0] mem_wdata,
    input logic [11:0] mem_rdata,
    input logic        done
);
    // R13: strobes exclusive
    a_r13_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}));

    // R13: read lasts one cycle and is followed by a quiet data cycle
    a_r13_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (!mem_rd && !mem_wr));

    // R5: write-back only two cycles after a read
    a_r5_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd, 2));

    // R5: written value is read data plus one
    a_r5_wr_value: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_wdata == 12'($past(mem_rdata) + 12'd1)));

    // R5: write-back only to autoincrement locations
    a_r5_wr_loc: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr[11:0] >= 12'o0010 && mem_addr[11:0] <= 12'o0017));

    // R12: done is a single pulse
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: direct reference finishes next cycle without memory
    a_r2_direct_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (irq || !instr[8])) |=> (done && !mem_rd && !mem_wr));

    // R10: interrupt requires zero fields
    a_r10_irq_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && irq) |-> (dfld == 3'd0 && ifld == 3'd0));
endmodule

bind mref_addr_seq mref_addr_seq_chk u_chk (.*);

// File: tb/mref_addr_seq_bench.sv
module mref_addr_seq_bench;
    localparam time TCK = 8ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] instr = '0;
    logic [14:0] pc = '0;
    logic [2:0]  dfld = '0, ifld = '0;
    logic        irq = 1'b0;
    logic        busy, mem_rd, mem_wr, done;
    logic [14:0] mem_addr, op_addr, next_pc, ret_pc;
    logic [11:0] mem_wdata;
    logic [11:0] mem_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [14:0] wr_addr;
    logic [11:0] wr_data;
    logic [11:0] wmem [int];

    always #(TCK/2) clk = ~clk;

    mref_addr_seq u_mref_addr_seq (.*);

    function automatic logic [11:0] memval(input logic [14:0] a);
        if (wmem.exists(int'(a))) return wmem[int'(a)];
        return 12'((int'(a) * 2917 + 77) & 12'hFFF);
    endfunction

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= memval(mem_addr);
            rd_cnt++;
        end
        if (mem_wr) begin
            wmem[int'(mem_addr)] = mem_wdata;
            wr_addr = mem_addr;
            wr_data = mem_wdata;
            wr_cnt++;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0o exp=%0o", req, act, exp);
        end
    endtask

    task automatic run_vec(input logic [11:0] ins, input logic [14:0] p,
                           input logic [2:0] df, input logic [2:0] fi,
                           input logic ir, input logic poke);
        logic [11:0] e, lo, ptr, tgt;
        logic [2:0]  op;
        logic        ind, inc, memop;
        logic [14:0] loc, seq, e_addr, e_npc, e_ret;
        int          e_lat, lat;
        e     = ir ? 12'o4000 : ins;
        op    = e[11:9];
        memop = (op <= 3'd5);
        ind   = memop && e[8];
        lo    = {(e[7] ? p[11:7] : 5'd0), e[6:0]};
        loc   = {df, lo};
        inc   = ind && (op == 3'd0 || op == 3'd1 || op == 3'd3) && lo >= 12'o10 && lo <= 12'o17;
        ptr   = memval(loc);
        tgt   = ind ? (inc ? ptr + 12'd1 : ptr) : lo;
        e_lat = ind ? (inc ? 4 : 3) : 1;
        seq   = {p[14:12], p[11:0] + 12'd1};
        e_ret = ir ? p : seq;
        if (!memop) e_addr = '0;
        else        e_addr = {(op == 3'd4 || op == 3'd5) ? fi : df, tgt};
        if (op == 3'd5)      e_npc = {fi, tgt};
        else if (op == 3'd4) e_npc = {fi, tgt + 12'd1};
        else                 e_npc = seq;

        rd_cnt = 0; wr_cnt = 0;
        @(negedge clk);
        start = 1'b1; instr = ins; pc = p; dfld = df; ifld = fi; irq = ir;
        @(negedge clk);
        start = poke; instr = 12'o5377; irq = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        start = 1'b0;
        chk(lat == e_lat, ind ? (inc ? "R5 latency" : "R4 latency") : "R2/R11 latency", lat, e_lat);
        chk(op_addr == e_addr, ind ? "R4/R6 op_addr" : (e[7] ? "R3 op_addr" : "R2 op_addr"), op_addr, e_addr);
        chk(next_pc == e_npc, op == 3'd5 ? "R8 next_pc" : (op == 3'd4 ? "R9 next_pc" : "R7 next_pc"), next_pc, e_npc);
        if (op == 3'd4) chk(ret_pc == e_ret, ir ? "R10 ret_pc" : "R9 ret_pc", ret_pc, e_ret);
        chk(rd_cnt == (ind ? 1 : 0), "R13 read count", rd_cnt, ind ? 1 : 0);
        chk(wr_cnt == (inc ? 1 : 0), "R5 write count", wr_cnt, inc ? 1 : 0);
        if (inc) begin
            chk(wr_addr == loc, "R5 write addr", wr_addr, loc);
            chk(wr_data == tgt, "R5 write data", wr_data, tgt);
        end
        @(negedge clk);
        chk(!done && !busy, "R12 done pulse", {done, busy}, 0);
    endtask

    initial begin
        #(TCK * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1729));
        repeat (3) @(negedge clk);
        chk(!done && !busy && !mem_rd && !mem_wr, "R1 in reset", {done, busy, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !busy && !mem_rd && !mem_wr, "R1 after reset", {done, busy, mem_rd, mem_wr}, 0);

        // R2 page zero direct TAD
        run_vec(12'o1055, 15'o21234, 3'd3, 3'd6, 1'b0, 1'b0);
        // R3 current page direct AND
        run_vec(12'o0255, 15'o21234, 3'd3, 3'd6, 1'b0, 1'b0);
        // R5 autoinc with pointer wrap 7777 -> 0
        wmem[int'(15'o50010)] = 12'o7777;
        run_vec(12'o0410, 15'o00100, 3'd5, 3'd1, 1'b0, 1'b0);
        // R5 ISZ through autoinc location: no write
        run_vec(12'o2412, 15'o00100, 3'd2, 3'd1, 1'b0, 1'b0);
        // R8 indirect jump through 0015, no write
        run_vec(12'o5415, 15'o10200, 3'd4, 3'd7, 1'b0, 1'b0);
        // R9 call to 7777 wraps to 0
        wmem[int'(15'o10020)] = 12'o7777;
        run_vec(12'o4420, 15'o01000, 3'd1, 3'd2, 1'b0, 1'b0);
        // R7 sequential wrap within field
        run_vec(12'o3100, 15'o37777, 3'd0, 3'd3, 1'b0, 1'b0);
        // R10 interrupt
        run_vec(12'o1234, 15'o04321, 3'd0, 3'd0, 1'b1, 1'b0);
        // R11 operate and IOT
        run_vec(12'o7300, 15'o12345, 3'd2, 3'd4, 1'b0, 1'b0);
        run_vec(12'o6031, 15'o07777, 3'd2, 3'd4, 1'b0, 1'b0);
        // R12 start while busy ignored (autoinc indirect DCA)
        run_vec(12'o3417, 15'o02000, 3'd6, 3'd2, 1'b0, 1'b1);

        for (int i = 0; i < 400; i++) begin
            logic [11:0] ins;
            logic [14:0] p;
            logic [2:0]  df, fi;
            logic        ir;
            ins = 12'($urandom);
            p   = 15'($urandom);
            df  = 3'($urandom);
            fi  = 3'($urandom);
            ir  = ($urandom % 16) == 0;
            if (($urandom % 3) == 0) begin
                ins[7]   = 1'b0;
                ins[6:0] = 7'(8 + ($urandom % 8));
            end
            if (ir) begin df = 3'd0; fi = 3'd0; end
            run_vec(ins, p, df, fi, ir, ins[8] && ($urandom % 4) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule